// File: doc/BRIEF.md
# Trimmed Seconds Counter RTC

This block keeps a free-running seconds count in a slow always-on clock domain that runs at 32.768 kHz. A programmable prescaler divides the slow clock into a tick, and each tick adds one to a wide count. The count keeps running whether or not the fast bus clock is active.

Software works through a small register window clocked by the fast bus clock. The window has four registers: a control/status word, a trim value for the prescaler, a load-only register for setting the count, and a read-only register for sampling it. Trim and load values cross into the slow domain through toggle handshakes. While a crossing is in flight, a pending flag reads as set and further writes to that register are dropped. A read-side capture samples the slow count, so the value read never mixes bits from two different counts. A detector in the bus domain reports whether slow-clock edges are still arriving.

Top module: `rtc_toy`

## Requirements
- R1: After reset the control word reads zero in bits 0, 2 and 3, the trim register reads 32767, and the count reads 0.
- R2: Register map (addr_i): 0 = control/status, where bit 0 is the count enable (read/write), bit 1 is slow clock present, bit 2 is trim pending and bit 3 is count-load pending. 1 = trim (read/write, low TRIM_W bits). 2 = count load (write-only, reads 0). 3 = count sample (read-only, writes have no effect).
- R3: While enabled, the count increases by exactly one every trim+1 slow-clock cycles, and it wraps from all ones to zero.
- R4: While the enable bit is 0, the count holds its value.
- R5: An accepted write to address 2 makes bit 3 read 1 from the next bus cycle on. The new value is loaded at a slow-clock edge, after which bit 3 returns to 0.
- R6: A write to address 2 while bit 3 is 1 is ignored.
- R7: An accepted write to address 1 makes bit 2 read 1 until the slow domain holds the new trim. A write to address 1 while bit 2 is 1 is ignored, and the trim register reads back the last accepted value.
- R8: A count load clears the prescaler phase, so the first tick after a load comes exactly trim+1 slow-clock cycles after the loading edge.
- R9: Bit 1 is 1 after a slow-clock rising edge is seen within DET_WIN bus cycles. It falls to 0 when no edge arrives for DET_WIN bus cycles.
- R10: Every value read from address 3 is a value the slow count actually held. Successive changes seen while running step by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| lf_clk_i | input | 1 | 32.768 kHz slow clock |
| wr_i | input | 1 | Write strobe, one bus cycle per write |
| addr_i | input | 2 | Register select |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i, combinational |

## Verification
The bench loads random start values, including all ones, under random small trims. It counts slow-clock edges between observed count changes. A prescaler that is not cleared on load, or that compares off by one, shows up as a wrong edge count. A count that is torn or skips shows up as a step other than one. Back-to-back writes to the load and trim registers check that a second write landing in the pending window is dropped; a design that let it through would end with the second value. Writes to the read-only address are checked, and stopping the slow clock checks that the presence flag drops and then recovers.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_TRIM   = 2'd1,
    REG_CNT_LD = 2'd2,
    REG_CNT_RD = 2'd3
  } rtc_reg_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_OSC   = 1;
  localparam int CTL_TPEND = 2;
  localparam int CTL_CPEND = 3;
  localparam int CTL_BITS  = 4;
endpackage

// File: rtl/rtc_wr_xfer.sv
`timescale 1ns/1ps
// Bus-to-slow write crossing by toggle handshake; hold register stays stable while pending.
module rtc_wr_xfer #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         lf_clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         pend_o,
  output logic [W-1:0] hold_o,
  output logic         load_o
);
  logic         req_q, ack_s1, ack_s2;
  logic         rq_s1, rq_s2, rq_s3;
  logic [W-1:0] hold_q;

  assign pend_o = req_q ^ ack_s2;
  assign hold_o = hold_q;
  assign load_o = rq_s2 ^ rq_s3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      hold_q <= RST_VAL;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= rq_s3;
      ack_s2 <= ack_s1;
      if (wr_i && !pend_o) begin
        req_q  <= ~req_q;
        hold_q <= wdata_i;
      end
    end
  end

  always_ff @(posedge lf_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_s1 <= 1'b0;
      rq_s2 <= 1'b0;
      rq_s3 <= 1'b0;
    end else begin
      rq_s1 <= req_q;
      rq_s2 <= rq_s1;
      rq_s3 <= rq_s2;
    end
  end

  // R5 on the count instance, R7 on the trim instance
  p_pend_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !pend_o) |=> pend_o);
  p_hold_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |=> $stable(hold_q));
  p_one_load_r5: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
endmodule

// File: rtl/rtc_lf_core.sv
`timescale 1ns/1ps
// Slow-domain prescaler and seconds count.
module rtc_lf_core #(
  parameter int                CNT_W     = 32,
  parameter int                TRIM_W    = 16,
  parameter logic [TRIM_W-1:0] TRIM_INIT = '1
) (
  input  logic              lf_clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cnt_ld_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  input  logic              trim_ld_i,
  input  logic [TRIM_W-1:0] trim_val_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic              en_s1, en_s2;
  logic [TRIM_W-1:0] trim_q, pre_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              tick;

  assign tick  = en_s2 && (pre_q >= trim_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge lf_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_s1  <= 1'b0;
      en_s2  <= 1'b0;
      trim_q <= TRIM_INIT;
    end else begin
      en_s1 <= en_i;
      en_s2 <= en_s1;
      if (trim_ld_i) trim_q <= trim_val_i;
    end
  end

  always_ff @(posedge lf_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (cnt_ld_i) begin
      pre_q <= '0;
      cnt_q <= cnt_val_i;
    end else if (en_s2) begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q + CNT_W'(1);
      end else begin
        pre_q <= pre_q + TRIM_W'(1);
      end
    end
  end

  p_step_r3: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    !cnt_ld_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_frozen_r4: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    (!en_s2 && !cnt_ld_i) |=> $stable(cnt_q));
  p_load_phase_r8: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    cnt_ld_i |=> (pre_q == '0 && cnt_q == $past(cnt_val_i)));
endmodule

// File: rtl/rtc_osc_det.sv
`timescale 1ns/1ps
// Bus-domain slow-clock presence detector.
module rtc_osc_det #(
  parameter int WIN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lf_clk_i,
  output logic ok_o
);
  localparam int WIN_W = $clog2(WIN + 1);
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN - 1);

  logic             s1, s2, s3, rise;
  logic [WIN_W-1:0] win_q;
  logic             ok_q;

  assign rise = s2 & ~s3;
  assign ok_o = ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      s3    <= 1'b0;
      win_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      s1 <= lf_clk_i;
      s2 <= s1;
      s3 <= s2;
      if (rise) begin
        win_q <= '0;
        ok_q  <= 1'b1;
      end else if (win_q != LAST) begin
        win_q <= win_q + WIN_W'(1);
      end else begin
        ok_q <= 1'b0;
      end
    end
  end

  p_seen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> ok_q);
  p_lost_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise && win_q == LAST) |=> !ok_q);
endmodule

// File: rtl/rtc_rd_sync.sv
`timescale 1ns/1ps
// Stable-twice capture of the slow count into the bus domain.
module rtc_rd_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] samp_q, rd_q;

  assign q_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      rd_q   <= '0;
    end else begin
      samp_q <= src_i;
      if (samp_q == src_i) rd_q <= samp_q;
    end
  end

  p_no_torn_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_q != src_i) |=> $stable(rd_q));
endmodule

// File: rtl/rtc_toy.sv
`timescale 1ns/1ps
module rtc_toy
  import rtc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int TRIM_W   = 16,
  parameter int TRIM_RST = 32767,
  parameter int DET_WIN  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lf_clk_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o
);
  localparam logic [TRIM_W-1:0] TRIM_INIT = TRIM_W'(TRIM_RST);

  rtc_reg_e          sel;
  logic              en_q, osc_ok;
  logic              trim_pend, trim_ld, cnt_pend, cnt_ld;
  logic [TRIM_W-1:0] trim_hold;
  logic [CNT_W-1:0]  cnt_hold, cnt_lf, cnt_rd;

  assign sel = rtc_reg_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     en_q <= 1'b0;
    else if (wr_i && sel == REG_CTRL) en_q <= wdata_i[CTL_EN];
  end

  rtc_wr_xfer #(.W(TRIM_W), .RST_VAL(TRIM_INIT)) u_trim_xfer (
    .clk_i    (clk_i),
    .lf_clk_i (lf_clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i && sel == REG_TRIM),
    .wdata_i  (wdata_i[TRIM_W-1:0]),
    .pend_o   (trim_pend),
    .hold_o   (trim_hold),
    .load_o   (trim_ld)
  );

  rtc_wr_xfer #(.W(CNT_W), .RST_VAL('0)) u_cnt_xfer (
    .clk_i    (clk_i),
    .lf_clk_i (lf_clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i && sel == REG_CNT_LD),
    .wdata_i  (wdata_i),
    .pend_o   (cnt_pend),
    .hold_o   (cnt_hold),
    .load_o   (cnt_ld)
  );

  rtc_lf_core #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .TRIM_INIT(TRIM_INIT)) u_core (
    .lf_clk_i   (lf_clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .cnt_ld_i   (cnt_ld),
    .cnt_val_i  (cnt_hold),
    .trim_ld_i  (trim_ld),
    .trim_val_i (trim_hold),
    .cnt_o      (cnt_lf)
  );

  rtc_osc_det #(.WIN(DET_WIN)) u_osc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lf_clk_i (lf_clk_i),
    .ok_o     (osc_ok)
  );

  rtc_rd_sync #(.W(CNT_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (cnt_lf),
    .q_o    (cnt_rd)
  );

  always_comb begin
    unique case (sel)
      REG_CTRL:   rdata_o = {{(CNT_W-CTL_BITS){1'b0}}, cnt_pend, trim_pend, osc_ok, en_q};
      REG_TRIM:   rdata_o = {{(CNT_W-TRIM_W){1'b0}}, trim_hold};
      REG_CNT_LD: rdata_o = '0;
      default:    rdata_o = cnt_rd;
    endcase
  end

  p_ro_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == REG_CNT_RD && !cnt_pend) |=> !cnt_pend);
endmodule

// File: tb/sim_rtc_toy.sv
`timescale 1ns/1ps
module sim_rtc_toy;
  logic        clk = 1'b0, rst_n = 1'b0, lf_clk = 1'b0, lf_run = 1'b1;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  int          checks = 0, fails = 0, lf_edges = 0;
  bit          done = 1'b0;

  rtc_toy u0 (
    .clk_i(clk), .rst_ni(rst_n), .lf_clk_i(lf_clk),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  always #2.5 clk = ~clk;

  // slow clock: half periods alternate 6/7 bus cycles, edges 1 ns after a bus edge
  initial begin
    forever begin
      repeat (6) @(posedge clk);
      #1 lf_clk = lf_run ? ~lf_clk : 1'b0;
      repeat (7) @(posedge clk);
      #1 lf_clk = lf_run ? ~lf_clk : 1'b0;
    end
  end

  always @(posedge lf_clk) lf_edges <= lf_edges + 1;

  function automatic logic [31:0] f_next(logic [31:0] v);
    return v + 32'd1;
  endfunction

  function automatic bit f_bit(logic [31:0] ctrl, int idx);
    return ctrl[idx];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic wait_clear(int idx, string req);
    logic [31:0] c;
    int n = 0;
    do begin bus_rd(2'd0, c); n++; end while (f_bit(c, idx) && n < 2000);
    chk(!f_bit(c, idx), req, c, 32'd0);
  endtask

  // wait until count sample differs from v; return new value and edge stamp
  task automatic wait_change(logic [31:0] v, output logic [31:0] nv, output int stamp);
    int n = 0;
    do begin bus_rd(2'd3, nv); n++; end while (nv == v && n < 3000);
    stamp = lf_edges;
  endtask

  task automatic load_measure(int t, logic [31:0] v);
    logic [31:0] c, v1, v2;
    int n = 0, e0, e1, e2;
    bus_wr(2'd1, t);
    wait_clear(2, "R7");
    bus_wr(2'd2, v);
    do begin bus_rd(2'd3, c); n++; end while (c != v && n < 3000);
    e0 = lf_edges;
    chk(c == v, "R5", c, v);
    wait_change(v, v1, e1);
    chk(e1 - e0 == t + 1, "R8", e1 - e0, t + 1);
    chk(v1 == f_next(v), "R3", v1, f_next(v));
    wait_change(v1, v2, e2);
    chk(e2 - e1 == t + 1, "R3", e2 - e1, t + 1);
    chk(v2 == f_next(v1), "R10", v2, f_next(v1));
    wait_clear(3, "R5");
  endtask

  task automatic summary();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      summary();
    end
  end

  initial begin
    logic [31:0] d, base;
    int e;
    void'($urandom(32'h5eed_0071));
    repeat (8) @(negedge clk);
    rst_n = 1'b1;

    bus_rd(2'd0, d); chk((d & 32'hD) == 0, "R1", d, 32'd0);
    bus_rd(2'd1, d); chk(d == 32'd32767, "R1", d, 32'd32767);
    bus_rd(2'd3, d); chk(d == 32'd0, "R1", d, 32'd0);

    repeat (40) @(negedge clk);
    bus_rd(2'd0, d); chk(f_bit(d, 1), "R9", d[1], 1'b1);
    bus_rd(2'd2, d); chk(d == 32'd0, "R2", d, 32'd0);

    // load while disabled, second write lands in pending window
    bus_wr(2'd2, 32'h0000_1000);
    bus_rd(2'd0, d); chk(f_bit(d, 3), "R5", d[3], 1'b1);
    bus_wr(2'd2, 32'h0000_2000);
    wait_clear(3, "R5");
    repeat (5) @(negedge clk);
    bus_rd(2'd3, d); chk(d == 32'h1000, "R6", d, 32'h1000);

    // writes to the sample register do nothing
    bus_wr(2'd3, 32'h0000_ABCD);
    bus_rd(2'd0, d); chk(!f_bit(d, 3), "R2", d[3], 1'b0);
    repeat (30) @(negedge clk);
    bus_rd(2'd3, d); chk(d == 32'h1000, "R2", d, 32'h1000);

    // trim crossing and drop of a write while pending
    bus_wr(2'd1, 32'd5);
    bus_rd(2'd0, d); chk(f_bit(d, 2), "R7", d[2], 1'b1);
    bus_wr(2'd1, 32'd9);
    bus_rd(2'd1, d); chk(d == 32'd5, "R7", d, 32'd5);
    wait_clear(2, "R7");
    bus_rd(2'd1, d); chk(d == 32'd5, "R7", d, 32'd5);

    // disabled: count frozen
    e = lf_edges;
    while (lf_edges - e < 30) @(negedge clk);
    bus_rd(2'd3, d); chk(d == 32'h1000, "R4", d, 32'h1000);

    bus_wr(2'd0, 32'd1);
    bus_rd(2'd0, d); chk(f_bit(d, 0), "R2", d[0], 1'b1);

    load_measure(5, 32'hFFFF_FFFF);
    load_measure(0, 32'h7FFF_FFFE);
    for (int i = 0; i < 10; i++) begin
      load_measure($urandom_range(0, 6), $urandom);
    end

    // disable while running: must hold
    bus_wr(2'd0, 32'd0);
    e = lf_edges;
    while (lf_edges - e < 4) @(negedge clk);
    bus_rd(2'd3, base);
    e = lf_edges;
    while (lf_edges - e < 25) @(negedge clk);
    bus_rd(2'd3, d); chk(d == base, "R4", d, base);

    // slow clock stops and restarts
    lf_run = 1'b0;
    repeat (200) @(negedge clk);
    bus_rd(2'd0, d); chk(!f_bit(d, 1), "R9", d[1], 1'b0);
    lf_run = 1'b1;
    repeat (100) @(negedge clk);
    bus_rd(2'd0, d); chk(f_bit(d, 1), "R9", d[1], 1'b1);

    summary();
  end
endmodule